// File: doc/BRIEF.md
# Clock-Scaled Peripheral Access Wait Generator

This block keeps back-to-back CPU I/O accesses to a slow video or sound device at least about 3 µs apart, whatever CPU clock rate is selected. Software writes an 8-bit system control word. Its upper nibble names the current clock rate, one of sixteen, and one bit turns throttling off. Each time an access to the slow device ends, a down-counter is loaded with a seed chosen for the current rate. The counter then counts one step per CPU clock. If the next access to the device begins before the count has run out, the block asks the CPU to wait until it has.

The seeds grow faster than linearly with the rate index. This keeps the spacing in real time roughly constant across all sixteen rates. Rate index zero is the slowest clock, and there the device needs no throttling, so waits are suppressed. The disable bit lets monitor software run an interrupt handler at full speed.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake. The write strobe is sampled on every clock edge, and the wait request is a combinational function of the access qualifier and the block's state.

Top module: `slow_io_wait_gen`

## Requirements
- R1: On a clock edge with `sysctl_we` high, the whole `sysctl_data` byte is captured into the control register. Bits [7:4] are the rate index and bit 3 is the disable bit.
- R2: The rate index r selects a counter seed. For r = 0..15 the seeds are 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31, 35, 39, 43, 47.
- R3: The spacing counter is 7 bits wide and its top bit is always zero. An access ends at the first clock edge where `slow_io` is low after having been high. At that edge the counter loads the seed. On every other edge it decrements, and it holds once it reaches zero.
- R4: `cpu_wait` is high exactly while `slow_io` is high, waits are enabled and the counter is nonzero. If an access starts g cycles after the previous one ended, it is stalled for max(0, seed − g + 1) cycles.
- R5: When the rate index is 0, `cpu_wait` stays low.
- R6: When bit 3 of the control register is 1, `cpu_wait` stays low.
- R7: Control bits [2:0] are stored but have no effect on the wait length.
- R8: A rate change takes effect only at the next counter load. A countdown already running is not altered. A control write on the same edge as a load still loads the seed of the old rate.
- R9: On reset the control register and the counter clear to zero, so `cpu_wait` is low.
- R10: `cpu_wait` is never high while `slow_io` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one edge per T-state |
| rst_n | input | 1 | Active-low reset |
| sysctl_we | input | 1 | Write strobe for the system control port |
| sysctl_data | input | 8 | Data bus byte written to the control port |
| slow_io | input | 1 | High during an I/O cycle aimed at the slow device |
| cpu_wait | output | 1 | Wait request to the CPU, active high |

## Verification
A control-register write and a counter load can fall on the same clock edge. This happens when software changes the rate in the cycle in which an access to the slow device ends. The bench provokes this by raising `sysctl_we` with a new rate at the same negative edge where it drops `slow_io`. It then checks that the following access is stalled for a number of cycles computed from the old rate's seed. It also checks that the access after that is stalled according to the new rate's seed. The main sweep covers every rate, with the disable bit both clear and set, at four gap lengths between accesses. This includes gaps equal to the seed and one cycle longer.

// File: rtl/swg_pkg.sv
package swg_pkg;
  localparam int RATE_W = 4;
  localparam int SEED_W = 6;

  // Piecewise seed law: unit steps over the first four rates, steps of two
  // over the middle eight, steps of four over the last four.
  function automatic logic [SEED_W-1:0] seed_for_rate(input logic [RATE_W-1:0] r);
    logic [SEED_W-1:0] r6;
    r6 = {{(SEED_W-RATE_W){1'b0}}, r};
    if (r < 4'd4)
      seed_for_rate = 6'd12 + r6;
    else if (r < 4'd12)
      seed_for_rate = {r6[4:0], 1'b0} + 6'd9;
    else
      seed_for_rate = {r6[3:0], 2'b00} - 6'd13;
  endfunction
endpackage

// File: rtl/swg_ctl_reg.sv
module swg_ctl_reg #(
  parameter int DATA_W   = 8,
  parameter int RATE_LSB = 4,
  parameter int RATE_W   = 4,
  parameter int OFF_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [RATE_W-1:0] rate,
  output logic              hold_off
);
  logic [DATA_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (we)
      ctl_q <= din;
  end

  assign rate     = ctl_q[RATE_LSB +: RATE_W];
  assign hold_off = ctl_q[OFF_BIT];

  // R1
  ctl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctl_q == $past(din));

  // R1
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q));
endmodule

// File: rtl/swg_seed_sel.sv
module swg_seed_sel
  import swg_pkg::*;
#(
  parameter int RW = RATE_W,
  parameter int SW = SEED_W
) (
  input  logic [RW-1:0] rate,
  output logic [SW-1:0] seed
);
  localparam int NRATES = 1 << RW;

  logic [SW-1:0] seed_tab [NRATES];

  for (genvar i = 0; i < NRATES; i++) begin : g_seed
    assign seed_tab[i] = seed_for_rate(RW'(i));
  end

  assign seed = seed_tab[rate];
endmodule

// File: rtl/swg_spacing_ctr.sv
module swg_spacing_ctr #(
  parameter int SEED_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_io,
  input  logic [SEED_W-1:0] seed,
  output logic [CNT_W-1:0]  cnt,
  output logic              busy
);
  localparam int PAD_W = CNT_W - SEED_W;

  logic             io_q;
  logic             acc_end;
  logic [CNT_W-1:0] cnt_q;

  assign acc_end = io_q & ~slow_io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      io_q <= slow_io;
      if (acc_end)
        cnt_q <= {{PAD_W{1'b0}}, seed};
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt  = cnt_q;
  assign busy = (cnt_q != '0);

  // R3
  ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_q && !slow_io) |=> cnt_q == {{PAD_W{1'b0}}, $past(seed)});

  // R3
  ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_q && !slow_io) && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R3
  ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_q && !slow_io) && cnt_q == '0) |=> cnt_q == '0);

  // R3
  ctr_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CNT_W-1] == 1'b0);
endmodule

// File: rtl/slow_io_wait_gen.sv
module slow_io_wait_gen
  import swg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RATE_LSB = 4,
  parameter int OFF_BIT  = 3,
  parameter int CNT_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sysctl_we,
  input  logic [DATA_W-1:0] sysctl_data,
  input  logic              slow_io,
  output logic              cpu_wait
);
  logic [RATE_W-1:0] rate;
  logic              hold_off;
  logic [SEED_W-1:0] seed;
  logic [CNT_W-1:0]  ctr_cnt;
  logic              ctr_busy;
  logic              throttle_en;

  swg_ctl_reg #(
    .DATA_W  (DATA_W),
    .RATE_LSB(RATE_LSB),
    .RATE_W  (RATE_W),
    .OFF_BIT (OFF_BIT)
  ) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (sysctl_we),
    .din     (sysctl_data),
    .rate    (rate),
    .hold_off(hold_off)
  );

  swg_seed_sel #(
    .RW(RATE_W),
    .SW(SEED_W)
  ) u_seed (
    .rate(rate),
    .seed(seed)
  );

  swg_spacing_ctr #(
    .SEED_W(SEED_W),
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .slow_io(slow_io),
    .seed   (seed),
    .cnt    (ctr_cnt),
    .busy   (ctr_busy)
  );

  assign throttle_en = (rate != '0) & ~hold_off;
  assign cpu_wait    = slow_io & throttle_en & ctr_busy;

  // R5
  wait_rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |-> !cpu_wait);

  // R6
  wait_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> !cpu_wait);

  // R4
  wait_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> ctr_cnt != '0);

  // R10
  wait_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> slow_io);
endmodule

// File: tb/tb_slow_io_wait_gen.sv
`timescale 1ns/1ps
module tb_slow_io_wait_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysctl_we = 1'b0;
  logic [7:0] sysctl_data = 8'h00;
  logic       slow_io = 1'b0;
  logic       cpu_wait;

  int n_chk = 0;
  int n_bad = 0;
  int r10_bad = 0;

  int seed_ref [16] = '{12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31, 35, 39, 43, 47};

  always #2 clk = ~clk;

  slow_io_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .sysctl_we(sysctl_we),
    .sysctl_data(sysctl_data), .slow_io(slow_io), .cpu_wait(cpu_wait)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    sysctl_we = 1'b1;
    sysctl_data = v;
    @(negedge clk);
    sysctl_we = 1'b0;
  endtask

  // Called at a negedge+1 inside an access; counts stalled cycles.
  task automatic count_waits(output int n);
    n = 0;
    while (cpu_wait && n < 200) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  // At a negedge: end the access, stay idle g cycles, start the next one.
  task automatic gap(input int g, input bit wr, input logic [7:0] v);
    slow_io = 1'b0;
    if (wr) begin
      sysctl_we = 1'b1;
      sysctl_data = v;
    end
    for (int i = 0; i < g; i++) begin
      #1;
      if (cpu_wait) r10_bad++;
      @(negedge clk);
      sysctl_we = 1'b0;
    end
    slow_io = 1'b1;
    #1;
  endtask

  task automatic open_access();
    int d;
    @(negedge clk);
    slow_io = 1'b1;
    #1;
    count_waits(d);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    int s;
    int e;
    int gaps [4];
    logic [7:0] v;

    slow_io = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_wait == 1'b0, "R9 wait low in reset", int'(cpu_wait), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cpu_wait == 1'b0, "R9 wait low after reset", int'(cpu_wait), 0);
    @(negedge clk);
    gap(1, 1'b0, 8'h00);
    count_waits(n);
    chk(n == 0, "R9 R5 cleared control gives no waits", n, 0);
    @(negedge clk);
    slow_io = 1'b0;

    // R1 R2 R4 R5 R6 R7: all rates, disable clear and set, four gap lengths
    for (int dis = 0; dis < 2; dis++) begin
      for (int r = 0; r < 16; r++) begin
        s = seed_ref[r];
        gaps[0] = 1; gaps[1] = 5; gaps[2] = s; gaps[3] = s + 1;
        for (int gi = 0; gi < 4; gi++) begin
          v = {r[3:0], dis[0], r[2:0] ^ 3'b101};
          wr_ctl(v);
          open_access();
          gap(gaps[gi], 1'b0, 8'h00);
          count_waits(n);
          e = (r != 0 && dis == 0) ? ((s - gaps[gi] + 1 > 0) ? s - gaps[gi] + 1 : 0) : 0;
          if (r == 0)
            chk(n == e, "R5 rate zero", n, e);
          else if (dis != 0)
            chk(n == e, "R6 disable bit", n, e);
          else
            chk(n == e, "R1 R2 R4 R7 stall length", n, e);
          @(negedge clk);
          slow_io = 1'b0;
        end
      end
    end

    // R3: a long gap lets the counter reach zero and stay there
    wr_ctl(8'hF0);
    open_access();
    gap(90, 1'b0, 8'h00);
    count_waits(n);
    chk(n == 0, "R3 counter stops at zero", n, 0);
    @(negedge clk);
    slow_io = 1'b0;

    // R8: the control write lands on the same edge as the counter load
    wr_ctl(8'hF0);
    open_access();
    gap(1, 1'b1, 8'h10);
    count_waits(n);
    chk(n == 47, "R8 load uses old rate", n, 47);
    @(negedge clk);
    gap(1, 1'b0, 8'h00);
    count_waits(n);
    chk(n == 13, "R8 next load uses new rate", n, 13);
    @(negedge clk);

    // R8: a write in the middle of the gap does not alter the countdown
    gap(4, 1'b0, 8'h00);
    count_waits(n);
    chk(n == 10, "R8 baseline rate 1 gap 4", n, 10);
    @(negedge clk);
    slow_io = 1'b0;
    @(negedge clk);
    sysctl_we = 1'b1;
    sysctl_data = 8'hC0;
    @(negedge clk);
    sysctl_we = 1'b0;
    slow_io = 1'b1;
    #1;
    count_waits(n);
    chk(n == 12, "R8 running countdown kept", n, 12);
    @(negedge clk);
    slow_io = 1'b0;

    chk(r10_bad == 0, "R10 no wait while idle", r10_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule